// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block is a five-pin bidirectional I/O port that sits on a simple register bus of a microcontroller-class chip. Software controls each pin through a direction register, an output latch, an analog-select register and an open-drain control register. Reading the port data address returns the synchronized pin levels. Writing that address updates the output latch. A second address reads and writes the latch directly.

On-chip peripherals can take over any pin through three per-pin override inputs. A peripheral output enable takes the pin's data and direction. A peripheral input force releases the pin's driver. Neither override ever changes the stored direction register. Pins selected as analog read as zero on the digital side, but their output driver stays usable. Open-drain drive can be chosen per pin on the pins built to support it.

The bus decode is written as a small enumerated register selector. No sequencing state is needed: every write completes on the clock edge where `bus_we` is high, and reads are combinational.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads all ones (all inputs), the latch reads all zeros, the analog-select register reads ANALOG_MASK, the open-drain register reads zero, and every `pad_oe` bit is 0.
- R2: With no override on a pin, a direction bit of 0 sets `pad_oe` to 1 and drives the latch bit on `pad_out`. A direction bit of 1 sets `pad_oe` to 0.
- R3: A write to address 0 (port data) or to address 1 (latch) loads the latch on that clock edge. Reading address 1 returns the latch.
- R4: Reading address 0 returns `pad_in` through a two-flop synchronizer. A change at the pins appears on the read only after two rising clock edges.
- R5: When `per_out_en` is 1 on a pin, `pad_oe` is 1 and the pin carries `per_out_dat`, whatever the direction bit and the latch hold.
- R6: When `per_in_force` is 1 and `per_out_en` is 0 on a pin, `pad_oe` is 0 even if the direction bit is 0. If both are 1, `per_out_en` wins.
- R7: The override inputs never alter the direction register. A read of address 2 returns only the value that software wrote.
- R8: Address 3 is the analog-select register. Its bits for pins outside ANALOG_MASK read as 0 and ignore writes. A pin whose analog-select bit is 1 reads as 0 at address 0. Clearing the bit makes the pin's level readable.
- R9: The analog-select bit does not gate the output driver. An output pin that is selected as analog still has `pad_oe` set to 1.
- R10: Address 4 is the open-drain register. Its bits for pins outside OD_MASK read as 0 and ignore writes. An open-drain output pin with data 0 drives `pad_oe`=1 and `pad_out`=0. With data 1 it sets `pad_oe`=0. Such a pin never drives a 1.
- R11: Addresses 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address (0 port, 1 latch, 2 direction, 3 analog select, 4 open drain) |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Combinational read data for `bus_addr` |
| per_out_en | input | 5 | Per-pin peripheral output takeover |
| per_out_dat | input | 5 | Per-pin peripheral output data |
| per_in_force | input | 5 | Per-pin peripheral force-to-input |
| pad_in | input | 5 | Asynchronous pin levels from the pads |
| pad_out | output | 5 | Per-pin output value to the pads |
| pad_oe | output | 5 | Per-pin output enable to the pads |

## Verification
The bench builds the port with its default parameters: five pins, ANALOG_MASK = 5'b00110 and OD_MASK = 5'b00011. Under this split, some pins are analog-capable and some are not, and some are open-drain-capable and some are not. Both the masked-write paths and the normal paths of R8 and R10 are therefore reached on the same build. The open-drain-capable pins also overlap a push-pull pin inside one output pattern, so both generate variants of the pin mux are driven side by side.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_PORT  = 3'd0,
        REG_LAT   = 3'd1,
        REG_DIR   = 3'd2,
        REG_ANSEL = 3'd3,
        REG_ODC   = 3'd4
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N_PINS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] async_in,
    output logic [N_PINS-1:0] sync_out
);
    logic [N_PINS-1:0] stage1_q;
    logic [N_PINS-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int                N_PINS      = 5,
    parameter logic [N_PINS-1:0] ANALOG_MASK = 5'b00110,
    parameter logic [N_PINS-1:0] OD_MASK     = 5'b00011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    input  logic [N_PINS-1:0] pin_sync,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] lat_q,
    output logic [N_PINS-1:0] ansel_q,
    output logic [N_PINS-1:0] odc_q,
    output logic [N_PINS-1:0] bus_rdata
);
    gpio_reg_e reg_sel;
    logic      wr_lat;
    logic      wr_dir;
    logic      wr_ansel;
    logic      wr_odc;

    assign reg_sel = gpio_reg_e'(bus_addr);

    always_comb begin
        wr_lat   = 1'b0;
        wr_dir   = 1'b0;
        wr_ansel = 1'b0;
        wr_odc   = 1'b0;
        unique case (reg_sel)
            REG_PORT, REG_LAT: wr_lat   = bus_we;
            REG_DIR:           wr_dir   = bus_we;
            REG_ANSEL:         wr_ansel = bus_we;
            REG_ODC:           wr_odc   = bus_we;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            lat_q   <= '0;
            ansel_q <= ANALOG_MASK;
            odc_q   <= '0;
        end else begin
            if (wr_lat)   lat_q   <= bus_wdata;
            if (wr_dir)   dir_q   <= bus_wdata;
            if (wr_ansel) ansel_q <= bus_wdata & ANALOG_MASK;
            if (wr_odc)   odc_q   <= bus_wdata & OD_MASK;
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_PORT:  bus_rdata = pin_sync & ~ansel_q;
            REG_LAT:   bus_rdata = lat_q;
            REG_DIR:   bus_rdata = dir_q;
            REG_ANSEL: bus_rdata = ansel_q;
            REG_ODC:   bus_rdata = odc_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R3: either data address loads the latch with the written value
    a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == REG_PORT || bus_addr == REG_LAT)) |=> (lat_q == $past(bus_wdata)));

    // R7: direction register moves only on a software write to it
    a_r7_dir_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == REG_DIR) |=> $stable(dir_q));

    // R11: writes to unmapped addresses leave every register untouched
    a_r11_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr > REG_ODC) |=> $stable({dir_q, lat_q, ansel_q, odc_q}));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter bit OD_CAPABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_bit,
    input  logic lat_bit,
    input  logic odc_bit,
    input  logic per_oe,
    input  logic per_dat,
    input  logic per_in,
    output logic pad_out,
    output logic pad_oe
);
    logic drive_out;
    logic drive_dat;

    always_comb begin
        if (per_oe) begin
            drive_out = 1'b1;
            drive_dat = per_dat;
        end else if (per_in) begin
            drive_out = 1'b0;
            drive_dat = lat_bit;
        end else begin
            drive_out = ~dir_bit;
            drive_dat = lat_bit;
        end
    end

    generate
        if (OD_CAPABLE) begin : g_od
            always_comb begin
                if (odc_bit) begin
                    pad_out = 1'b0;
                    pad_oe  = drive_out & ~drive_dat;
                end else begin
                    pad_out = drive_dat;
                    pad_oe  = drive_out;
                end
            end
        end else begin : g_pp
            logic unused_odc;
            assign unused_odc = odc_bit;
            assign pad_out    = drive_dat;
            assign pad_oe     = drive_out;
        end
    endgenerate

    // R5: a peripheral takeover always ends with the pad driven or released to a high level
    a_r5_periph_drives: assert property (@(posedge clk) disable iff (!rst_n)
        per_oe |-> (pad_oe ? (pad_out == (per_dat & ~(OD_CAPABLE & odc_bit))) : (per_dat && OD_CAPABLE && odc_bit)));

    // R6: forced input with no peripheral output releases the pad
    a_r6_force_input: assert property (@(posedge clk) disable iff (!rst_n)
        (per_in && !per_oe) |-> !pad_oe);

    // R10: an open-drain pin never drives a one
    a_r10_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (OD_CAPABLE && odc_bit && pad_oe) |-> !pad_out);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int                N_PINS      = 5,
    parameter logic [N_PINS-1:0] ANALOG_MASK = 5'b00110,
    parameter logic [N_PINS-1:0] OD_MASK     = 5'b00011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] per_out_en,
    input  logic [N_PINS-1:0] per_out_dat,
    input  logic [N_PINS-1:0] per_in_force,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] lat_q;
    logic [N_PINS-1:0] ansel_q;
    logic [N_PINS-1:0] odc_q;

    gpio_sync #(.N_PINS(N_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(
        .N_PINS      (N_PINS),
        .ANALOG_MASK (ANALOG_MASK),
        .OD_MASK     (OD_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .ansel_q   (ansel_q),
        .odc_q     (odc_q),
        .bus_rdata (bus_rdata)
    );

    logic unused_ansel;
    assign unused_ansel = ^ansel_q;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            gpio_pin_mux #(.OD_CAPABLE(OD_MASK[i])) u_mux (
                .clk     (clk),
                .rst_n   (rst_n),
                .dir_bit (dir_q[i]),
                .lat_bit (lat_q[i]),
                .odc_bit (odc_q[i]),
                .per_oe  (per_out_en[i]),
                .per_dat (per_out_dat[i]),
                .per_in  (per_in_force[i]),
                .pad_out (pad_out[i]),
                .pad_oe  (pad_oe[i])
            );
        end
    endgenerate

    // R9: an output pin keeps its driver whatever its analog selection
    a_r9_analog_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (per_out_en != '0) |-> ((pad_oe & per_out_en & ~odc_q) == (per_out_en & ~odc_q)));
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] per_out_en = '0;
    logic [N-1:0] per_out_dat = '0;
    logic [N-1:0] per_in_force = '0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpio_port uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .per_out_en   (per_out_en),
        .per_out_dat  (per_out_dat),
        .per_in_force (per_in_force),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        reg_read(3'd2, v); check("R1 dir reset", v, 5'b11111);
        reg_read(3'd1, v); check("R1 latch reset", v, 5'b00000);
        reg_read(3'd3, v); check("R1 ansel reset", v, 5'b00110);
        reg_read(3'd4, v); check("R1 odc reset", v, 5'b00000);
        check("R1 oe reset", pad_oe, 5'b00000);
    endtask

    task automatic t_direction();
        reg_write(3'd1, 5'b10101);
        reg_write(3'd2, 5'b11000);
        #1;
        check("R2 oe follows dir", pad_oe, 5'b00111);
        check("R2 out follows latch", pad_out, 5'b10101);
    endtask

    task automatic t_latch_addrs();
        logic [N-1:0] v;
        reg_write(3'd0, 5'b01010);
        reg_read(3'd1, v); check("R3 port addr writes latch", v, 5'b01010);
        reg_write(3'd1, 5'b10011);
        reg_read(3'd1, v); check("R3 latch addr writes latch", v, 5'b10011);
        check("R3 latch on pads", pad_out, 5'b10011);
    endtask

    task automatic t_input_sync();
        logic [N-1:0] v;
        @(negedge clk);
        pad_in = 5'b11111;
        bus_addr = 3'd0;
        #1 check("R4 no change before edges", bus_rdata, 5'b00000);
        @(negedge clk);
        #1 check("R4 hidden after one edge", bus_rdata, 5'b00000);
        @(negedge clk);
        #1 check("R4 visible after two edges, analog masked R8", bus_rdata, 5'b11001);
        reg_write(3'd3, 5'b00000);
        reg_read(3'd0, v); check("R8 digital after ansel clear", v, 5'b11111);
        reg_write(3'd3, 5'b11111);
        reg_read(3'd3, v); check("R8 ansel mask", v, 5'b00110);
        reg_read(3'd0, v); check("R8 analog reads zero", v, 5'b11001);
        pad_in = 5'b00000;
    endtask

    task automatic t_analog_out();
        reg_write(3'd2, 5'b00000);
        #1 check("R9 analog pins still drive", pad_oe, 5'b11111);
    endtask

    task automatic t_periph_out();
        logic [N-1:0] v;
        reg_write(3'd2, 5'b11111);
        reg_write(3'd1, 5'b00000);
        @(negedge clk);
        per_out_en  = 5'b00101;
        per_out_dat = 5'b00100;
        #1;
        check("R5 periph enables", pad_oe, 5'b00101);
        check("R5 periph data", pad_out & pad_oe, 5'b00100);
        reg_read(3'd2, v); check("R7 dir unchanged by periph out", v, 5'b11111);
        @(negedge clk);
        per_out_en = '0; per_out_dat = '0;
    endtask

    task automatic t_periph_in();
        logic [N-1:0] v;
        reg_write(3'd2, 5'b00000);
        @(negedge clk);
        per_in_force = 5'b00011;
        per_out_en   = 5'b00001;
        #1 check("R6 force input, out_en wins", pad_oe, 5'b11101);
        reg_read(3'd2, v); check("R7 dir unchanged by force", v, 5'b00000);
        @(negedge clk);
        per_in_force = '0; per_out_en = '0;
    endtask

    task automatic t_open_drain();
        logic [N-1:0] v;
        reg_write(3'd2, 5'b00000);
        reg_write(3'd1, 5'b00010);
        reg_write(3'd4, 5'b11111);
        reg_read(3'd4, v); check("R10 odc mask", v, 5'b00011);
        check("R10 od enables", pad_oe, 5'b11101);
        check("R10 od outputs", pad_out, 5'b00000);
        reg_write(3'd4, 5'b00000);
        #1 check("R10 push-pull restored", pad_out, 5'b00010);
    endtask

    task automatic t_unmapped();
        logic [N-1:0] v;
        reg_write(3'd2, 5'b01100);
        reg_write(3'd1, 5'b00110);
        reg_write(3'd5, 5'b11111);
        reg_write(3'd7, 5'b10001);
        reg_read(3'd5, v); check("R11 unmapped reads zero", v, 5'b00000);
        reg_read(3'd2, v); check("R11 dir untouched", v, 5'b01100);
        reg_read(3'd1, v); check("R11 latch untouched", v, 5'b00110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_latch_addrs();
        t_input_sync();
        t_analog_out();
        t_periph_out();
        t_periph_in();
        t_open_drain();
        t_unmapped();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule